// File: doc/BRIEF.md
# Memory controller event counter unit

This block is the statistics engine of a DRAM controller. It owns a bank of programmable counters that each watch a chosen set of controller event strobes, plus two dedicated counters that tally read and write commands. Each event arrives as a one-cycle-per-occurrence pulse. Software drives the block through a simple 64-bit register port: one write port and one read port with a combinational read path.

A programmable counter is armed by writing its configuration word. That word holds an enable bit and a bitmap of the strobes the counter should watch. A global run control can confine programmable counting to the interval between a start command and an end command. The two command counters have their own enables and clear strobes and ignore the run control. Every counter is `CNT_W` bits wide and keeps a sticky wrap flag next to its count.

Top module: `dram_evt_monitor`

## Requirements
- R1: After reset every mapped register reads zero: the mode, run and done registers, every configuration word, every counter value, and the command-counter enable register.
- R2: Programmable counter n has a configuration word at 0x8040+8n. Bit 63 is the enable and bits EVT_W-1:0 are the bitmap; the word reads back exactly as written. An event numbered ID drives strobe bit ID-1, and bitmap bit ID-1 selects it. While the counter is enabled and counting is allowed, its value, read at 0x8080+8n, rises by one in every cycle in which any selected strobe is high. Strobes that are not selected have no effect.
- R3: The power-state entry events with IDs 27, 31 and 35 each own four adjacent strobes, one per rank, starting at bit ID-1. A bitmap covering all four counts one per cycle when any of them is high, even if several are high in the same cycle.
- R4: When the mode register (0x8020, bit 0) is 1, programmable counting is allowed only between a write of bit 0 to the start register (0x8028) and a write of bit 0 to the end register (0x8030). The start register reads 1 at bit 1 while running. The done register (0x8038) reads 1 at bit 0 after an end write and returns to 0 on the next start write.
- R5: When the mode register bit 0 is 0, enabled programmable counters count regardless of the start and end registers.
- R6: Writing a configuration word clears that counter's value and its wrap flag.
- R7: The command-counter enable register (0x80C0) enables the write-command counter with bit 0 and the read-command counter with bit 1. The counters read at 0x80D0 (writes) and 0x80D8 (reads), count one per input pulse cycle, and do not depend on the run control.
- R8: A write to 0x80C8 with bit 0 set clears the write-command counter, and with bit 1 set clears the read-command counter. The clear acts once: the register reads zero and the counter counts again from the next cycle.
- R9: A counter at its maximum value wraps to zero on its next increment and sets bit CNT_W of its value register. That bit stays set until the counter is cleared.
- R10: Reads of unmapped or unaligned offsets return zero, and writes to counter value addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write byte offset |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 16 | Register read byte offset |
| rd_data | output | 64 | Register read data (combinational) |
| evt_i | input | EVT_W | Controller event strobes, bit ID-1 for event ID |
| rd_cmd_i | input | 1 | Read command issued this cycle |
| wr_cmd_i | input | 1 | Write command issued this cycle |

## Verification
Register writes, clears and start/end commands take effect at the first rising edge that samples `wr_en`. A read made at the following falling edge already shows the new value, because the read path has no register. An event strobe held for k rising edges adds exactly k to each selected counter, and that count can be read at the falling edge after the last of those edges. The bench drives every input just after a falling edge and samples `rd_data` one time unit after a falling edge, so each expected count is simply the number of rising edges during which the stimulus was held.

// File: rtl/dem_pkg.sv
package dem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] OFS_MODE     = 16'h8020;
  localparam logic [ADDR_W-1:0] OFS_GO       = 16'h8028;
  localparam logic [ADDR_W-1:0] OFS_HALT     = 16'h8030;
  localparam logic [ADDR_W-1:0] OFS_DONE     = 16'h8038;
  localparam logic [ADDR_W-1:0] OFS_CFG_BASE = 16'h8040;
  localparam logic [ADDR_W-1:0] OFS_VAL_BASE = 16'h8080;
  localparam logic [ADDR_W-1:0] OFS_FREE_EN  = 16'h80C0;
  localparam logic [ADDR_W-1:0] OFS_FREE_CLR = 16'h80C8;
  localparam logic [ADDR_W-1:0] OFS_FREE_WR  = 16'h80D0;
  localparam logic [ADDR_W-1:0] OFS_FREE_RD  = 16'h80D8;

  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_RUN  = 2'd1,
    GATE_DONE = 2'd2
  } gate_state_e;
endpackage

// File: rtl/dem_gate.sv
module dem_gate
  import dem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic manual,
  input  logic go_pulse,
  input  logic halt_pulse,
  output logic active,
  output logic ended,
  output logic count_ok
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (go_pulse)        state_d = GATE_RUN;
    else if (halt_pulse) state_d = GATE_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_IDLE;
    else        state_q <= state_d;
  end

  assign active   = (state_q == GATE_RUN);
  assign ended    = (state_q == GATE_DONE);
  assign count_ok = manual ? active : 1'b1;
endmodule

// File: rtl/dem_counter.sv
module dem_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             wrapped
);
  logic [CNT_W-1:0] val_d;
  logic             wrap_d;
  logic             upd;

  always_comb begin
    val_d  = value;
    wrap_d = wrapped;
    upd    = clr | inc;
    if (clr) begin
      val_d  = '0;
      wrap_d = 1'b0;
    end else if (inc) begin
      val_d  = value + 1'b1;
      wrap_d = wrapped | (&value);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      wrapped <= 1'b0;
    end else if (upd) begin
      value   <= val_d;
      wrapped <= wrap_d;
    end
  end
endmodule

// File: rtl/dem_evt_sel.sv
module dem_evt_sel #(
  parameter int EVT_W = 63
) (
  input  logic             enable,
  input  logic [EVT_W-1:0] bitmap,
  input  logic [EVT_W-1:0] evt,
  output logic             hit
);
  assign hit = enable & (|(bitmap & evt));
endmodule

// File: rtl/dram_evt_monitor.sv
module dram_evt_monitor
  import dem_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 63,
  parameter int CNT_W    = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [15:0]       rd_addr,
  output logic [63:0]       rd_data,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              rd_cmd_i,
  input  logic              wr_cmd_i
);
  localparam int STRIDE = 8;
  localparam int EN_BIT = DATA_W - 1;

  logic                              manual_q, manual_d;
  logic [1:0]                        free_en_q, free_en_d;
  logic [NUM_PROG-1:0]               cfg_en_q;
  logic [NUM_PROG-1:0][EVT_W-1:0]    cfg_map_q;
  logic [NUM_PROG-1:0]               cfg_wr;
  logic [NUM_PROG-1:0]               hit;
  logic [NUM_PROG-1:0][CNT_W-1:0]    prog_cnt;
  logic [NUM_PROG-1:0]               prog_ovf;
  logic [CNT_W-1:0]                  fix_wr_cnt, fix_rd_cnt;
  logic                              fix_wr_ovf, fix_rd_ovf;
  logic                              active, ended, count_ok;
  logic                              go_pulse, halt_pulse, free_clr_wr;

  assign go_pulse    = wr_en && (wr_addr == OFS_GO)       && wr_data[0];
  assign halt_pulse  = wr_en && (wr_addr == OFS_HALT)     && wr_data[0];
  assign free_clr_wr = wr_en && (wr_addr == OFS_FREE_CLR);

  always_comb begin
    manual_d  = manual_q;
    free_en_d = free_en_q;
    if (wr_en && wr_addr == OFS_MODE)    manual_d  = wr_data[0];
    if (wr_en && wr_addr == OFS_FREE_EN) free_en_d = wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual_q  <= 1'b0;
      free_en_q <= 2'b00;
    end else begin
      manual_q  <= manual_d;
      free_en_q <= free_en_d;
    end
  end

  dem_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .manual     (manual_q),
    .go_pulse   (go_pulse),
    .halt_pulse (halt_pulse),
    .active     (active),
    .ended      (ended),
    .count_ok   (count_ok)
  );

  for (genvar gi = 0; gi < NUM_PROG; gi++) begin : g_prog
    localparam logic [ADDR_W-1:0] CFG_A = OFS_CFG_BASE + ADDR_W'(STRIDE * gi);

    assign cfg_wr[gi] = wr_en && (wr_addr == CFG_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_en_q[gi]  <= 1'b0;
        cfg_map_q[gi] <= '0;
      end else if (cfg_wr[gi]) begin
        cfg_en_q[gi]  <= wr_data[EN_BIT];
        cfg_map_q[gi] <= wr_data[EVT_W-1:0];
      end
    end

    dem_evt_sel #(.EVT_W(EVT_W)) u_sel (
      .enable (cfg_en_q[gi]),
      .bitmap (cfg_map_q[gi]),
      .evt    (evt_i),
      .hit    (hit[gi])
    );

    dem_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg_wr[gi]),
      .inc     (hit[gi] & count_ok),
      .value   (prog_cnt[gi]),
      .wrapped (prog_ovf[gi])
    );
  end

  dem_counter #(.CNT_W(CNT_W)) u_fix_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (free_clr_wr & wr_data[0]),
    .inc     (free_en_q[0] & wr_cmd_i),
    .value   (fix_wr_cnt),
    .wrapped (fix_wr_ovf)
  );

  dem_counter #(.CNT_W(CNT_W)) u_fix_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (free_clr_wr & wr_data[1]),
    .inc     (free_en_q[1] & rd_cmd_i),
    .value   (fix_rd_cnt),
    .wrapped (fix_rd_ovf)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFS_MODE)    rd_data[0]   = manual_q;
    if (rd_addr == OFS_GO)      rd_data[1]   = active;
    if (rd_addr == OFS_DONE)    rd_data[0]   = ended;
    if (rd_addr == OFS_FREE_EN) rd_data[1:0] = free_en_q;
    if (rd_addr == OFS_FREE_WR) begin
      rd_data[CNT_W]     = fix_wr_ovf;
      rd_data[CNT_W-1:0] = fix_wr_cnt;
    end
    if (rd_addr == OFS_FREE_RD) begin
      rd_data[CNT_W]     = fix_rd_ovf;
      rd_data[CNT_W-1:0] = fix_rd_cnt;
    end
    for (int i = 0; i < NUM_PROG; i++) begin
      if (rd_addr == OFS_CFG_BASE + ADDR_W'(STRIDE * i)) begin
        rd_data[EN_BIT]    = cfg_en_q[i];
        rd_data[EVT_W-1:0] = cfg_map_q[i];
      end
      if (rd_addr == OFS_VAL_BASE + ADDR_W'(STRIDE * i)) begin
        rd_data[CNT_W]     = prog_ovf[i];
        rd_data[CNT_W-1:0] = prog_cnt[i];
      end
    end
  end
endmodule

// File: rtl/dem_checker.sv
module dem_checker
  import dem_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [15:0]                    wr_addr,
  input logic [1:0]                     wr_lo,
  input logic [15:0]                    rd_addr,
  input logic [63:0]                    rd_data,
  input logic                           active,
  input logic                           ended,
  input logic [NUM_PROG-1:0][CNT_W-1:0] prog_cnt,
  input logic [NUM_PROG-1:0]            prog_ovf,
  input logic [CNT_W-1:0]               fix_wr_cnt
);
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_GO && wr_lo[0]) |=> (active && !ended)); // R4

  AST_END_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_HALT && wr_lo[0]) |=> (!active && ended)); // R4

  AST_FREE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_FREE_CLR && wr_lo[0]) |=> (fix_wr_cnt == '0)); // R8

  AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[2:0] != 3'b000) |-> (rd_data == '0)); // R10

  for (genvar gi = 0; gi < NUM_PROG; gi++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_cnt[gi] == $past(prog_cnt[gi])) ||
      (prog_cnt[gi] == $past(prog_cnt[gi]) + 1'b1) ||
      (prog_cnt[gi] == '0)); // R2

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_CFG_BASE + 16'(8 * gi))
      |=> (prog_cnt[gi] == '0 && !prog_ovf[gi])); // R6

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_ovf[gi]) |-> (prog_cnt[gi] == '0)); // R9
  end
endmodule

bind dram_evt_monitor dem_checker #(.NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_dem_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_lo      (wr_data[1:0]),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .active     (active),
  .ended      (ended),
  .prog_cnt   (prog_cnt),
  .prog_ovf   (prog_ovf),
  .fix_wr_cnt (fix_wr_cnt)
);

// File: tb/dram_evt_monitor_bench.sv
module dram_evt_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_EVT_W    = 63;
  localparam int B_CNT_W    = 8;

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [15:0]        wr_addr;
  logic [63:0]        wr_data;
  logic [15:0]        rd_addr;
  logic [63:0]        rd_data;
  logic [B_EVT_W-1:0] evt_i;
  logic               rd_cmd_i;
  logic               wr_cmd_i;

  int checks;
  int fails;
  bit done;

  dram_evt_monitor #(.NUM_PROG(8), .EVT_W(B_EVT_W), .CNT_W(B_CNT_W)) u_dram_evt_monitor (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .evt_i    (evt_i),
    .rd_cmd_i (rd_cmd_i),
    .wr_cmd_i (wr_cmd_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  localparam logic [15:0] A_MODE = 16'h8020, A_GO = 16'h8028, A_HALT = 16'h8030;
  localparam logic [15:0] A_DONE = 16'h8038, A_CFG = 16'h8040, A_VAL = 16'h8080;
  localparam logic [15:0] A_FEN = 16'h80C0, A_FCLR = 16'h80C8;
  localparam logic [15:0] A_FWR = 16'h80D0, A_FRD = 16'h80D8;
  localparam logic [63:0] EN = 64'h8000_0000_0000_0000;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_rd(input string tag, input logic [15:0] a, input logic [63:0] exp);
    logic [63:0] d;
    reg_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic hold_evt(input logic [B_EVT_W-1:0] v, input int n);
    @(negedge clk);
    evt_i = v;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic hold_cmd(input logic rd, input logic wr, input int n);
    @(negedge clk);
    rd_cmd_i = rd; wr_cmd_i = wr;
    repeat (n) @(negedge clk);
    rd_cmd_i = 1'b0; wr_cmd_i = 1'b0;
  endtask

  task automatic t_reset;
    expect_rd("R1 mode", A_MODE, 64'h0);
    expect_rd("R1 start", A_GO, 64'h0);
    expect_rd("R1 done", A_DONE, 64'h0);
    expect_rd("R1 cfg0", A_CFG, 64'h0);
    expect_rd("R1 cfg7", A_CFG + 16'd56, 64'h0);
    expect_rd("R1 val0", A_VAL, 64'h0);
    expect_rd("R1 free enable", A_FEN, 64'h0);
    expect_rd("R1 write count", A_FWR, 64'h0);
    expect_rd("R1 read count", A_FRD, 64'h0);
  endtask

  task automatic t_single_event;
    reg_wr(A_CFG, EN | 64'h4);
    expect_rd("R2 cfg readback", A_CFG, EN | 64'h4);
    hold_evt(63'h4, 5);
    hold_evt(63'h20, 3);
    expect_rd("R2 R5 count selected only", A_VAL, 64'd5);
  endtask

  task automatic t_multi_rank;
    reg_wr(A_CFG + 16'd8, EN | (64'hF << 26));
    hold_evt(63'hF << 26, 4);
    hold_evt(63'h1 << 28, 2);
    hold_evt(63'h1 << 25, 2);
    expect_rd("R3 rank group", A_VAL + 16'd8, 64'd6);
  endtask

  task automatic t_manual_gate;
    reg_wr(A_MODE, 64'h1);
    reg_wr(A_CFG + 16'd16, EN | 64'h1);
    hold_evt(63'h1, 3);
    expect_rd("R4 no count before start", A_VAL + 16'd16, 64'd0);
    expect_rd("R4 idle not active", A_GO, 64'h0);
    reg_wr(A_GO, 64'h1);
    expect_rd("R4 active flag", A_GO, 64'h2);
    expect_rd("R4 done low while running", A_DONE, 64'h0);
    hold_evt(63'h1, 4);
    reg_wr(A_HALT, 64'h1);
    expect_rd("R4 done flag", A_DONE, 64'h1);
    expect_rd("R4 active cleared", A_GO, 64'h0);
    hold_evt(63'h1, 3);
    expect_rd("R4 frozen after end", A_VAL + 16'd16, 64'd4);
    reg_wr(A_GO, 64'h1);
    expect_rd("R4 restart clears done", A_DONE, 64'h0);
    reg_wr(A_MODE, 64'h0);
    reg_wr(A_HALT, 64'h1);
    hold_evt(63'h1, 2);
    expect_rd("R5 ungated after end", A_VAL + 16'd16, 64'd6);
  endtask

  task automatic t_cfg_clear;
    reg_wr(A_CFG, EN | 64'h4);
    expect_rd("R6 rewrite clears", A_VAL, 64'd0);
  endtask

  task automatic t_fixed;
    hold_cmd(1'b1, 1'b1, 3);
    expect_rd("R7 disabled write count", A_FWR, 64'd0);
    reg_wr(A_FEN, 64'h1);
    hold_cmd(1'b1, 1'b1, 4);
    expect_rd("R7 write counter", A_FWR, 64'd4);
    expect_rd("R7 read disabled", A_FRD, 64'd0);
    reg_wr(A_FEN, 64'h3);
    hold_cmd(1'b1, 1'b0, 2);
    expect_rd("R7 read counter", A_FRD, 64'd2);
    reg_wr(A_MODE, 64'h1);
    reg_wr(A_HALT, 64'h1);
    hold_cmd(1'b0, 1'b1, 2);
    expect_rd("R7 ignores run control", A_FWR, 64'd6);
    reg_wr(A_MODE, 64'h0);
  endtask

  task automatic t_fixed_clear;
    reg_wr(A_FCLR, 64'h2);
    expect_rd("R8 read cleared", A_FRD, 64'd0);
    expect_rd("R8 write kept", A_FWR, 64'd6);
    reg_wr(A_FCLR, 64'h1);
    expect_rd("R8 write cleared", A_FWR, 64'd0);
    expect_rd("R8 control reads zero", A_FCLR, 64'd0);
    hold_cmd(1'b0, 1'b1, 1);
    expect_rd("R8 resumes", A_FWR, 64'd1);
  endtask

  task automatic t_wrap;
    reg_wr(A_CFG + 16'd24, EN | 64'h2);
    hold_evt(63'h2, 255);
    expect_rd("R9 at max", A_VAL + 16'd24, 64'h0FF);
    hold_evt(63'h2, 1);
    expect_rd("R9 wrapped", A_VAL + 16'd24, 64'h100);
    hold_evt(63'h2, 2);
    expect_rd("R9 sticky", A_VAL + 16'd24, 64'h102);
    reg_wr(A_CFG + 16'd24, EN | 64'h2);
    expect_rd("R9 R6 flag cleared", A_VAL + 16'd24, 64'h0);
  endtask

  task automatic t_unmapped;
    expect_rd("R10 below map", 16'h8000, 64'h0);
    expect_rd("R10 unaligned", A_CFG + 16'd4, 64'h0);
    expect_rd("R10 gap", 16'h80E0, 64'h0);
    reg_wr(A_VAL, 64'hFF);
    expect_rd("R10 value read-only", A_VAL, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; evt_i = '0; rd_cmd_i = 1'b0; wr_cmd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_event();
    t_multi_rank();
    t_manual_gate();
    t_cfg_clear();
    t_fixed();
    t_fixed_clear();
    t_wrap();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule